// File: doc/BRIEF.md
# Bus Clock Frequency Band Estimator

This block classifies the reference bus clock into one of four standard bands. On a start request it first inspects a 32-bit stored count word. If the word carries the validity signature, its 9-bit count is taken as is. If not, the block falls back to measurement: it samples the low 9 bits of a live counter word 128 times, one sample every `SAMPLE_INTERVAL` clock cycles, and takes the floor of the mean.

The resulting count is multiplied by a base constant chosen by the chip variant and divided by 192, which gives the bus frequency in whole MHz. That frequency is then placed in a band with uneven limits. The block reports the 2-bit band slot and its nominal frequency. A one-cycle done pulse marks completion, and a valid flag stays high until the next request is accepted.

Top module: `bus_clock_band`

## Requirements
- R1: After reset, `slot` is 0, `nominalMhz` is 0, `bandValid` is 0 and `done` is 0.
- R2: A start accepted while idle with `storedWord[31:12]` equal to 20'hABCDE uses `storedWord[8:0]` as the count, with bits 11:9 having no effect. `done` rises one cycle after the accepting edge, so the latency is 1.
- R3: A start accepted while idle without that signature samples `liveWord` at the clock edges that fall `SAMPLE_INTERVAL`, 2×`SAMPLE_INTERVAL`, … 128×`SAMPLE_INTERVAL` cycles after the accepting edge. The count is the floor of the sum divided by 128, and the 16-bit accumulator never wraps.
- R4: Only `liveWord[8:0]` enters a sample; the upper bits of `liveWord` have no effect.
- R5: `baseSel` is captured when a start is accepted and selects the base constant: 0 gives 48, 1 gives 55, and 2 or 3 give 66. The frequency is floor(count × base / 192).
- R6: A frequency below 40 gives slot 0 and 33 MHz. Below 45 gives slot 1 and 40 MHz. Below 55 gives slot 2 and 50 MHz. Anything else gives slot 3 and 66 MHz.
- R7: `done` is a single-cycle pulse. `bandValid` goes low when a start is accepted, stays low while the block is busy, rises together with `done`, and then holds.
- R8: A start raised while a measurement is in progress is ignored. The running measurement, its captured base and its result are unchanged.
- R9: In the fallback path, `done` rises 128×`SAMPLE_INTERVAL`+2 cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request an estimate; acted on only when idle |
| storedWord | input | 32 | Stored count word; signature in bits 31:12, count in bits 8:0 |
| liveWord | input | 16 | Live counter word; the low 9 bits are sampled |
| baseSel | input | 2 | Variant base selector: 0→48, 1→55, 2/3→66 |
| slot | output | 2 | Band slot number |
| nominalMhz | output | 7 | Nominal frequency of the band in MHz |
| bandValid | output | 1 | Result valid; held until the next accepted start |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `storedWord` and `baseSel` are stable on the edge that accepts a start. They also assume that `liveWord` is settled on every clock edge, because any edge may be a sample point. The bench drives all inputs at the falling edge, so each value is stable across the next rising edge. It draws a fresh live value every cycle and sums only the values present at the sample edges it expects. It also pulses start in the middle of a measurement, with a valid signature and a different base, to show that the request is ignored.

// File: rtl/bcb_pkg.sv
package bcb_pkg;

  localparam int WORD_W = 32;
  localparam int SIG_W = 20;
  localparam logic [SIG_W-1:0] SIGNATURE = 20'hABCDE;
  localparam int NOMINAL_W = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_AVERAGE,
    ST_CONVERT
  } bcbState_t;

  typedef struct packed {
    logic accept;       // request taken: capture base, clear valid
    logic loadDirect;   // stored count goes straight to count register
    logic clearAcc;     // start of fallback accumulation
    logic addSample;    // add one live sample
    logic takeAverage;  // count <= accumulator / samples
    logic writeResult;  // register band outputs, pulse done
  } bcbStrobes_t;

endpackage

// File: rtl/bcb_band_map.sv
module bcb_band_map #(
  parameter int IN_W = 16,
  parameter int LIMIT_1 = 40,
  parameter int LIMIT_2 = 45,
  parameter int LIMIT_3 = 55,
  parameter int NOM_0 = 33,
  parameter int NOM_1 = 40,
  parameter int NOM_2 = 50,
  parameter int NOM_3 = 66
) (
  input  logic [IN_W-1:0]                freqMhz,
  output logic [1:0]                     bandSlot,
  output logic [bcb_pkg::NOMINAL_W-1:0]  bandNominal
);
  import bcb_pkg::*;

  always_comb begin
    if (freqMhz < IN_W'(LIMIT_1)) begin
      bandSlot = 2'd0;
      bandNominal = NOMINAL_W'(NOM_0);
    end else if (freqMhz < IN_W'(LIMIT_2)) begin
      bandSlot = 2'd1;
      bandNominal = NOMINAL_W'(NOM_1);
    end else if (freqMhz < IN_W'(LIMIT_3)) begin
      bandSlot = 2'd2;
      bandNominal = NOMINAL_W'(NOM_2);
    end else begin
      bandSlot = 2'd3;
      bandNominal = NOMINAL_W'(NOM_3);
    end
  end

endmodule

// File: rtl/bcb_control.sv
module bcb_control #(
  parameter int SAMPLES_LOG2 = 7,
  parameter int SAMPLE_INTERVAL = 750
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 sigOk,
  output bcb_pkg::bcbStrobes_t strobes,
  output logic                 busy
);
  import bcb_pkg::*;

  localparam int NUM_SAMPLES = 1 << SAMPLES_LOG2;
  localparam int TIMER_W = $clog2(SAMPLE_INTERVAL + 1);
  localparam int CNT_W = SAMPLES_LOG2 + 1;
  localparam logic [TIMER_W-1:0] TIMER_LAST = TIMER_W'(SAMPLE_INTERVAL - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_SAMPLES - 1);

  bcbState_t state, stateNext;
  logic [TIMER_W-1:0] timer;
  logic [CNT_W-1:0] sampleCnt;
  logic tick;

  assign tick = (state == ST_SAMPLE) && (timer == TIMER_LAST);
  assign busy = (state != ST_IDLE);

  always_comb begin
    strobes = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.accept = 1'b1;
          if (sigOk) begin
            strobes.loadDirect = 1'b1;
            stateNext = ST_CONVERT;
          end else begin
            strobes.clearAcc = 1'b1;
            stateNext = ST_SAMPLE;
          end
        end
      end
      ST_SAMPLE: begin
        if (tick) begin
          strobes.addSample = 1'b1;
          if (sampleCnt == CNT_LAST) stateNext = ST_AVERAGE;
        end
      end
      ST_AVERAGE: begin
        strobes.takeAverage = 1'b1;
        stateNext = ST_CONVERT;
      end
      ST_CONVERT: begin
        strobes.writeResult = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      timer <= '0;
      sampleCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobes.clearAcc) begin
        timer <= '0;
        sampleCnt <= '0;
      end else if (state == ST_SAMPLE) begin
        if (tick) begin
          timer <= '0;
          sampleCnt <= sampleCnt + 1'b1;
        end else begin
          timer <= timer + 1'b1;
        end
      end
    end
  end

  // R3: the sample timer never passes its interval
  assert_timer_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SAMPLE) |-> (timer < TIMER_W'(SAMPLE_INTERVAL)));

  // R3: exactly the configured number of samples, never more
  assert_sample_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AVERAGE) |-> (sampleCnt == CNT_W'(NUM_SAMPLES)));

  // R8: a start while busy never re-enters acceptance
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state != ST_CONVERT) |=> busy);

endmodule

// File: rtl/bcb_datapath.sv
module bcb_datapath #(
  parameter int COUNT_W = 9,
  parameter int SAMPLES_LOG2 = 7,
  parameter int LIVE_W = 16,
  parameter int BASE_0 = 48,
  parameter int BASE_1 = 55,
  parameter int BASE_2 = 66,
  parameter int DIVISOR = 192
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  bcb_pkg::bcbStrobes_t              strobes,
  input  logic [bcb_pkg::WORD_W-1:0]        storedWord,
  input  logic [LIVE_W-1:0]                 liveWord,
  input  logic [1:0]                        baseSel,
  output logic                              sigOk,
  output logic [1:0]                        slot,
  output logic [bcb_pkg::NOMINAL_W-1:0]     nominalMhz,
  output logic                              bandValid,
  output logic                              done
);
  import bcb_pkg::*;

  localparam int ACC_W = COUNT_W + SAMPLES_LOG2;
  localparam int BASE_W = 7;
  localparam int PROD_W = COUNT_W + BASE_W;

  logic [ACC_W-1:0] acc;
  logic [COUNT_W-1:0] countReg;
  logic [BASE_W-1:0] baseReg, baseNext;
  logic [PROD_W-1:0] product, freqMhz;
  logic [1:0] mapSlot;
  logic [NOMINAL_W-1:0] mapNominal;
  logic unusedLiveBits, unusedStoredBits;

  assign unusedLiveBits = ^liveWord[LIVE_W-1:COUNT_W];
  assign unusedStoredBits = ^storedWord[WORD_W-SIG_W-1:COUNT_W];

  assign sigOk = (storedWord[WORD_W-1 -: SIG_W] == SIGNATURE);

  always_comb begin
    unique case (baseSel)
      2'd0: baseNext = BASE_W'(BASE_0);
      2'd1: baseNext = BASE_W'(BASE_1);
      default: baseNext = BASE_W'(BASE_2);
    endcase
  end

  assign product = PROD_W'(countReg) * PROD_W'(baseReg);
  assign freqMhz = product / PROD_W'(DIVISOR);

  bcb_band_map #(.IN_W(PROD_W)) u_bandMap (
    .freqMhz(freqMhz),
    .bandSlot(mapSlot),
    .bandNominal(mapNominal)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      countReg <= '0;
      baseReg <= '0;
      slot <= '0;
      nominalMhz <= '0;
      bandValid <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= strobes.writeResult;
      if (strobes.accept) begin
        baseReg <= baseNext;
        bandValid <= 1'b0;
      end
      if (strobes.loadDirect) countReg <= storedWord[COUNT_W-1:0];
      if (strobes.clearAcc) acc <= '0;
      else if (strobes.addSample) acc <= acc + ACC_W'(liveWord[COUNT_W-1:0]);
      if (strobes.takeAverage) countReg <= acc[ACC_W-1 -: COUNT_W];
      if (strobes.writeResult) begin
        slot <= mapSlot;
        nominalMhz <= mapNominal;
        bandValid <= 1'b1;
      end
    end
  end

  // R3: accumulation never wraps around
  assert_acc_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.addSample |=> (acc >= $past(acc)));

  // R7: done lasts one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: done comes with a valid result
  assert_done_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bandValid);

  // R6: registered slot and nominal agree
  assert_slot_nominal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bandValid |-> ((slot == 2'd0 && nominalMhz == 7'd33) || (slot == 2'd1 && nominalMhz == 7'd40) ||
                   (slot == 2'd2 && nominalMhz == 7'd50) || (slot == 2'd3 && nominalMhz == 7'd66)));

endmodule

// File: rtl/bus_clock_band.sv
module bus_clock_band #(
  parameter int COUNT_W = 9,
  parameter int SAMPLES_LOG2 = 7,
  parameter int SAMPLE_INTERVAL = 750,
  parameter int LIVE_W = 16,
  parameter int BASE_0 = 48,
  parameter int BASE_1 = 55,
  parameter int BASE_2 = 66
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [31:0]          storedWord,
  input  logic [LIVE_W-1:0]    liveWord,
  input  logic [1:0]           baseSel,
  output logic [1:0]           slot,
  output logic [6:0]           nominalMhz,
  output logic                 bandValid,
  output logic                 done
);
  import bcb_pkg::*;

  bcbStrobes_t strobes;
  logic sigOk;
  logic busy;

  bcb_control #(
    .SAMPLES_LOG2(SAMPLES_LOG2),
    .SAMPLE_INTERVAL(SAMPLE_INTERVAL)
  ) u_control (
    .clk(clk),
    .rst_n(rst_n),
    .start(start),
    .sigOk(sigOk),
    .strobes(strobes),
    .busy(busy)
  );

  bcb_datapath #(
    .COUNT_W(COUNT_W),
    .SAMPLES_LOG2(SAMPLES_LOG2),
    .LIVE_W(LIVE_W),
    .BASE_0(BASE_0),
    .BASE_1(BASE_1),
    .BASE_2(BASE_2)
  ) u_datapath (
    .clk(clk),
    .rst_n(rst_n),
    .strobes(strobes),
    .storedWord(storedWord),
    .liveWord(liveWord),
    .baseSel(baseSel),
    .sigOk(sigOk),
    .slot(slot),
    .nominalMhz(nominalMhz),
    .bandValid(bandValid),
    .done(done)
  );

  // R2: signature path completes one cycle after acceptance
  assert_direct_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && sigOk) |=> ##1 done);

  // R7: no valid result is shown while a measurement runs
  assert_valid_low_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !bandValid);

endmodule

// File: tb/bus_clock_band_test.sv
`timescale 1ns/1ps
module bus_clock_band_test;

  localparam int INTERVAL = 3;
  localparam int FALLBACK_LAT = 128 * INTERVAL + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] storedWord = '0;
  logic [15:0] liveWord = '0;
  logic [1:0] baseSel = '0;
  logic [1:0] slot;
  logic [6:0] nominalMhz;
  logic bandValid;
  logic done;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  bus_clock_band #(.SAMPLE_INTERVAL(INTERVAL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .storedWord(storedWord),
    .liveWord(liveWord), .baseSel(baseSel), .slot(slot),
    .nominalMhz(nominalMhz), .bandValid(bandValid), .done(done)
  );

  function automatic int baseOf(input logic [1:0] sel);
    return (sel == 2'd0) ? 48 : (sel == 2'd1) ? 55 : 66;
  endfunction

  function automatic int slotOf(input int freq);
    if (freq < 40) return 0;
    if (freq < 45) return 1;
    if (freq < 55) return 2;
    return 3;
  endfunction

  function automatic int nominalOf(input int s);
    case (s)
      0: return 33;
      1: return 40;
      2: return 50;
      default: return 66;
    endcase
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // centre: mean of the 9-bit live values in fallback runs
  task automatic runCase(input logic [31:0] word, input logic [1:0] bsel,
                         input int centre, input bit inject, input string tag);
    bit sigGood;
    int sum, obsLat, cnt, freq, expSlot, expLat;
    sigGood = (word[31:12] == 20'hABCDE);
    sum = 0;
    obsLat = -1;
    @(negedge clk);
    storedWord = word;
    baseSel = bsel;
    liveWord = 16'($urandom);
    start = 1'b1;
    for (int m = 1; m <= 1000; m++) begin
      @(negedge clk);
      if (m == 1) start = 1'b0;
      if (done) begin
        obsLat = m - 1;
        break;
      end
      if (m == 2) check({"R7 valid low while busy ", tag}, int'(bandValid), 0);
      begin
        int v9;
        v9 = centre + int'($urandom % 7) - 3;
        if (v9 < 0) v9 = 0;
        if (v9 > 511) v9 = 511;
        liveWord = {7'($urandom), 9'(v9)};  // R4: upper bits random
        if (!sigGood && (m % INTERVAL == 0) && (m / INTERVAL >= 1) && (m / INTERVAL <= 128))
          sum += v9;
      end
      if (inject && m == 5) begin  // R8: request while busy
        storedWord = {20'hABCDE, 12'h1FF};
        baseSel = 2'd2;
        start = 1'b1;
      end
      if (inject && m == 6) start = 1'b0;
    end
    cnt = sigGood ? int'(word[8:0]) : (sum >> 7);
    freq = (cnt * baseOf(bsel)) / 192;
    expSlot = slotOf(freq);
    expLat = sigGood ? 1 : FALLBACK_LAT;
    check({sigGood ? "R2 latency " : "R9 latency ", tag}, obsLat, expLat);
    check({"R6/R5/R3/R4 slot ", tag}, int'(slot), expSlot);
    check({"R6 nominal ", tag}, int'(nominalMhz), nominalOf(expSlot));
    check({"R7 valid with done ", tag}, int'(bandValid), 1);
    @(negedge clk);
    check({"R7 done single cycle ", tag}, int'(done), 0);
    check({"R7 valid held ", tag}, int'(bandValid), 1);
  endtask

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 slot", int'(slot), 0);
    check("R1 nominal", int'(nominalMhz), 0);
    check("R1 valid", int'(bandValid), 0);
    check("R1 done", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6 thresholds with base 48 (freq = count/4); bits 11:9 set (R2)
    runCase({20'hABCDE, 3'b111, 9'd159}, 2'd0, 0, 0, "R2 cnt159");
    runCase({20'hABCDE, 3'b101, 9'd160}, 2'd0, 0, 0, "R2 cnt160");
    runCase({20'hABCDE, 3'b000, 9'd179}, 2'd0, 0, 0, "R6 cnt179");
    runCase({20'hABCDE, 3'b010, 9'd180}, 2'd0, 0, 0, "R6 cnt180");
    runCase({20'hABCDE, 3'b000, 9'd219}, 2'd0, 0, 0, "R6 cnt219");
    runCase({20'hABCDE, 3'b000, 9'd220}, 2'd0, 0, 0, "R6 cnt220");
    // R5 each base selector
    runCase({20'hABCDE, 12'd140}, 2'd1, 0, 0, "R5 base55");
    runCase({20'hABCDE, 12'd140}, 2'd2, 0, 0, "R5 base66a");
    runCase({20'hABCDE, 12'd100}, 2'd3, 0, 0, "R5 base66b");
    runCase({20'hABCDE, 12'd511}, 2'd1, 0, 0, "R5 max");
    runCase({20'hABCDE, 12'd0}, 2'd2, 0, 0, "R6 zero");

    // random direct cases
    for (int i = 0; i < 20; i++)
      runCase({20'hABCDE, 12'($urandom)}, 2'($urandom), 0, 0, "R2 random");

    // fallback: near-miss signature and random words
    runCase({20'hABCDF, 12'd200}, 2'd0, 170, 0, "R3 badsig");
    runCase(32'h0000_0000, 2'd0, 160, 0, "R3 c160");
    runCase(32'h1234_5678, 2'd2, 120, 0, "R3 c120 base66");
    runCase(32'hFFFF_FFFF, 2'd1, 511, 0, "R3 R4 max");
    runCase(32'h0ABC_DE00, 2'd0, 0, 0, "R3 min");
    // R8: start during measurement ignored
    runCase(32'h0000_0001, 2'd0, 150, 1, "R8 inject");
    for (int i = 0; i < 3; i++)
      runCase({20'h00000, 12'($urandom)}, 2'($urandom), int'($urandom % 512), 0, "R3 random");

    summary();
  end

endmodule